// File: doc/BRIEF.md
# Configurable Asynchronous Serial Line Unit

This block is a full-duplex asynchronous serial port. A byte offered on a valid/ready transmit interface is sent on a serial output as a low start bit, the data bits with the least significant bit first, an optional parity bit and a high stop period. A receiver on the serial input rebuilds characters of the same format. It reports each finished character with a one-cycle strobe and three error flags.

The frame format is set by static inputs that both directions share: data length, parity enable, parity sense and stop length. The transmit and receive bit rates each have their own selector. Each direction derives a 16x oversampling tick from the single system clock through a divisor. The divisor comes from a constant table that is computed at elaboration from the clock-frequency parameter. Each direction latches the configuration when a character begins, so a change made during a character has no effect until the next one.

Transmitter states are TX_IDLE, TX_START, TX_DATA, TX_PAR and TX_STOP. The transitions are:
- TX_IDLE to TX_START when a byte is accepted.
- TX_START to TX_DATA after 16 ticks.
- TX_DATA to TX_DATA after each bit that is not the last one.
- TX_DATA to TX_PAR or TX_STOP after the last bit, depending on parity enable.
- TX_PAR to TX_STOP after 16 ticks.
- TX_STOP to TX_IDLE after 16, 24 or 32 ticks.

Receiver states are RX_IDLE, RX_START, RX_DATA, RX_PAR and RX_STOP. The transitions are:
- RX_IDLE to RX_START on a falling edge of the synchronised input.
- RX_START to RX_DATA at the mid-bit point (8 ticks) if the input is still low.
- RX_START to RX_IDLE at the mid-bit point if the input has gone high again.
- RX_DATA to RX_PAR or RX_STOP after the last data sample.
- RX_PAR to RX_STOP after the parity sample.
- RX_STOP to RX_IDLE at the middle of the first stop bit, where the character completes.

Top module: `sl_unit`

## Requirements
- R1: `cfg_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Each character starts with one low start bit, followed by the data bits with the least significant bit first.
- R2: When `cfg_par_en` is 1, a parity bit follows the last data bit. When it is 0, no parity bit is sent and none is expected on receive.
- R3: With parity enabled, `cfg_par_odd`=1 makes the number of ones in the data plus parity bit odd, and 0 makes it even. `cfg_par_odd` has no effect when parity is disabled.
- R4: `cfg_stop_one`=1 gives a stop period of one bit. `cfg_stop_one`=0 gives two bits for 6 to 8 data bits, and 1.5 bits (24 ticks) for 5 data bits.
- R5: Rate codes 0 to 7 select 110, 150, 300, 600, 1200, 2400, 4800 and 9600 baud. One bit lasts 16 ticks, and one tick lasts round(CLK_HZ / (16 x baud)) clock cycles, with a minimum of 1.
- R6: `cfg_tx_rate` sets only the transmit timing and `cfg_rx_rate` sets only the receive timing. The two may differ while both directions are active.
- R7: `tx_ready` is 1 exactly when the transmitter is idle, and `txd` is high whenever it is idle. A byte is accepted on a clock edge with `tx_valid` and `tx_ready` both 1. The start bit appears on `txd` in the cycle after that edge. A new byte can be accepted in the first cycle that `tx_ready` returns to 1.
- R8: Both directions sample all configuration inputs only when a character begins. A change during a character does not alter that character.
- R9: The receiver confirms a start bit at its mid-point. A low pulse shorter than half a bit produces no character.
- R10: `rx_valid` is a one-cycle pulse for each received character. `rx_data` is right-aligned, with the unused upper bits at 0.
- R11: `rx_frame_err` is 1 with a character whose first stop bit was sampled low.
- R12: `rx_par_err` is 1 with a character whose received parity bit does not match the configured sense. It is always 0 when parity is disabled.
- R13: `rx_overrun` is 1 with a character that completes while the previous one is still unacknowledged. A cycle with `rx_ack`=1 acknowledges the pending character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_stop_one | input | 1 | One stop bit when 1 |
| cfg_tx_rate | input | 3 | Transmit rate code |
| cfg_rx_rate | input | 3 | Receive rate code |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle, byte can be taken |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_ack | input | 1 | Acknowledges the last received character |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle strobe for a finished character |
| rx_par_err | output | 1 | Parity mismatch for this character |
| rx_frame_err | output | 1 | Stop bit sampled low for this character |
| rx_overrun | output | 1 | Previous character was not acknowledged |

## Verification
The transmitter is exercised with all four data lengths and with every combination of parity and stop setting. Three of these patterns separate the cases: the 5-bit frame with the wide stop setting tells the 24-tick stop period apart from the 32-tick one; even and odd parity on different data tell the parity sense apart; and odd sense with parity off shows that the sense input is ignored. Back-to-back bytes check the first-cycle acceptance, and a configuration change in mid-character shows that the latched settings are used. On the receive side, hand-built frames with a wrong parity bit, a low stop bit or a short low glitch separate the two error flags and the start confirmation. Two unacknowledged characters in a row test the overrun flag. Running the two directions at different rates at the same time shows that the rate selectors are independent.

// File: rtl/sl_pkg.sv
package sl_pkg;

    localparam int unsigned OVERSAMPLE = 16;
    localparam int unsigned NUM_RATES  = 8;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       stop_one;
    } frame_cfg_t;

    function automatic int unsigned rate_baud(input int unsigned code);
        case (code)
            0:       return 110;
            1:       return 150;
            2:       return 300;
            3:       return 600;
            4:       return 1200;
            5:       return 2400;
            6:       return 4800;
            default: return 9600;
        endcase
    endfunction

    function automatic int unsigned rate_div(input int unsigned clk_hz, input int unsigned code);
        int unsigned b;
        int unsigned d;
        b = rate_baud(code);
        d = (clk_hz + (b * OVERSAMPLE) / 2) / (b * OVERSAMPLE);
        return (d == 0) ? 1 : d;
    endfunction

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

endpackage

// File: rtl/sl_baud_tick.sv
module sl_baud_tick #(
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R5: the cycle counter never passes the selected divisor
    p_cnt_below_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < div));

endmodule

// File: rtl/sl_tx.sv
module sl_tx
    import sl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  frame_cfg_t cfg,
    input  logic [2:0] rate_in,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    input  logic       tick,
    output logic       tx_ready,
    output logic       txd,
    output logic       run,
    output logic [2:0] rate_q
);

    tx_state_e  state_q, state_d;
    frame_cfg_t cfg_q;
    logic [7:0] data_q;
    logic       par_q;
    logic [4:0] ph_q;
    logic [2:0] bit_q;
    logic [4:0] last_ph;
    logic [2:0] last_bit;
    logic       seg_end;
    logic       accept;
    logic [7:0] masked;

    assign masked   = tx_data & len_mask(cfg.len);
    assign accept   = (state_q == TX_IDLE) && tx_valid;
    assign last_bit = {1'b0, cfg_q.len} + 3'd4;

    always_comb begin
        if (state_q == TX_STOP) begin
            if (cfg_q.stop_one)          last_ph = 5'd15;
            else if (cfg_q.len == 2'd0)  last_ph = 5'd23;
            else                         last_ph = 5'd31;
        end else begin
            last_ph = 5'd15;
        end
    end

    assign seg_end = tick && (ph_q == last_ph);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (tx_valid) state_d = TX_START;
            TX_START: if (seg_end)  state_d = TX_DATA;
            TX_DATA:  if (seg_end && bit_q == last_bit)
                          state_d = cfg_q.par_en ? TX_PAR : TX_STOP;
            TX_PAR:   if (seg_end)  state_d = TX_STOP;
            TX_STOP:  if (seg_end)  state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            data_q <= '0;
            par_q  <= 1'b0;
            rate_q <= '0;
            ph_q   <= '0;
            bit_q  <= '0;
        end else if (accept) begin
            cfg_q  <= cfg;
            data_q <= masked;
            par_q  <= (^masked) ^ cfg.par_odd;
            rate_q <= rate_in;
            ph_q   <= '0;
            bit_q  <= '0;
        end else if (tick) begin
            ph_q <= seg_end ? 5'd0 : ph_q + 5'd1;
            if (seg_end && state_q == TX_DATA) bit_q <= bit_q + 3'd1;
        end
    end

    always_comb begin
        tx_ready = (state_q == TX_IDLE);
        run      = !tx_ready;
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = data_q[bit_q];
            TX_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    // R7: an idle line is high
    p_idle_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R1, R7: an accepted byte starts with a low start bit in the next cycle
    p_start_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!txd && !tx_ready));

    // R8: latched settings and data hold for the whole character
    p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ready && $past(!tx_ready)) |-> ($stable(cfg_q) && $stable(data_q) && $stable(rate_q)));

endmodule

// File: rtl/sl_rx.sv
module sl_rx
    import sl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  frame_cfg_t cfg,
    input  logic [2:0] rate_in,
    input  logic       rxd,
    input  logic       rx_ack,
    input  logic       tick,
    output logic       run,
    output logic [2:0] rate_q,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_par_err,
    output logic       rx_frame_err,
    output logic       rx_overrun
);

    rx_state_e  state_q, state_d;
    frame_cfg_t cfg_q;
    logic [2:0] sync_q;
    logic       line;
    logic       fall;
    logic [7:0] sh_q;
    logic       pbit_q;
    logic [4:0] ph_q;
    logic [2:0] bit_q;
    logic [2:0] last_bit;
    logic       seg_end;
    logic       start;
    logic       done;
    logic       pend_q;
    logic [1:0] out_len_q;

    assign line     = sync_q[1];
    assign fall     = sync_q[2] && !sync_q[1];
    assign start    = (state_q == RX_IDLE) && fall;
    assign last_bit = {1'b0, cfg_q.len} + 3'd4;
    assign seg_end  = tick && (ph_q == ((state_q == RX_START) ? 5'd7 : 5'd15));
    assign done     = (state_q == RX_STOP) && seg_end;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (fall)    state_d = RX_START;
            RX_START: if (seg_end) state_d = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (seg_end && bit_q == last_bit)
                          state_d = cfg_q.par_en ? RX_PAR : RX_STOP;
            RX_PAR:   if (seg_end) state_d = RX_STOP;
            RX_STOP:  if (seg_end) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 3'b111;
            cfg_q  <= '0;
            rate_q <= '0;
            sh_q   <= '0;
            pbit_q <= 1'b0;
            ph_q   <= '0;
            bit_q  <= '0;
        end else begin
            sync_q <= {sync_q[1:0], rxd};
            if (start) begin
                cfg_q  <= cfg;
                rate_q <= rate_in;
                sh_q   <= '0;
                ph_q   <= '0;
                bit_q  <= '0;
            end else if (tick) begin
                ph_q <= seg_end ? 5'd0 : ph_q + 5'd1;
                if (seg_end && state_q == RX_DATA) begin
                    sh_q[bit_q] <= line;
                    bit_q       <= bit_q + 3'd1;
                end
                if (seg_end && state_q == RX_PAR) pbit_q <= line;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            rx_par_err   <= 1'b0;
            rx_frame_err <= 1'b0;
            rx_overrun   <= 1'b0;
            pend_q       <= 1'b0;
            out_len_q    <= '0;
        end else begin
            rx_valid <= done;
            if (done) begin
                rx_data      <= sh_q;
                rx_par_err   <= cfg_q.par_en && (pbit_q != ((^sh_q) ^ cfg_q.par_odd));
                rx_frame_err <= !line;
                rx_overrun   <= pend_q && !rx_ack;
                out_len_q    <= cfg_q.len;
                pend_q       <= 1'b1;
            end else if (rx_ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign run = (state_q != RX_IDLE);

    // R10: the completion strobe lasts a single cycle
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10: bits above the character length read as zero
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data & ~len_mask(out_len_q)) == 8'h00));

    // R11: a low stop sample is reported with the character
    p_frame_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !line) |=> (rx_valid && rx_frame_err));

    // R13: completing over an unacknowledged character flags overrun
    p_overrun_flag_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pend_q && !rx_ack) |=> rx_overrun);

endmodule

// File: rtl/sl_unit.sv
module sl_unit
    import sl_pkg::*;
#(
    parameter int unsigned CLK_HZ = 1_843_200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop_one,
    input  logic [2:0] cfg_tx_rate,
    input  logic [2:0] cfg_rx_rate,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    input  logic       rx_ack,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_par_err,
    output logic       rx_frame_err,
    output logic       rx_overrun
);

    localparam int unsigned MAX_DIV = rate_div(CLK_HZ, 0);
    localparam int DIV_W = (MAX_DIV < 2) ? 1 : $clog2(MAX_DIV + 1);

    logic [DIV_W-1:0] div_tab [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
        assign div_tab[g] = DIV_W'(rate_div(CLK_HZ, g));
    end

    frame_cfg_t cfg;
    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd, stop_one: cfg_stop_one};

    logic       tx_run, tx_tick, rx_run, rx_tick;
    logic [2:0] tx_rate_q, rx_rate_q;

    sl_baud_tick #(.DIV_W(DIV_W)) u_tx_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (tx_run),
        .div  (div_tab[tx_rate_q]),
        .tick (tx_tick)
    );

    sl_baud_tick #(.DIV_W(DIV_W)) u_rx_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (rx_run),
        .div  (div_tab[rx_rate_q]),
        .tick (rx_tick)
    );

    sl_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .rate_in (cfg_tx_rate),
        .tx_data (tx_data),
        .tx_valid(tx_valid),
        .tick    (tx_tick),
        .tx_ready(tx_ready),
        .txd     (txd),
        .run     (tx_run),
        .rate_q  (tx_rate_q)
    );

    sl_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg),
        .rate_in     (cfg_rx_rate),
        .rxd         (rxd),
        .rx_ack      (rx_ack),
        .tick        (rx_tick),
        .run         (rx_run),
        .rate_q      (rx_rate_q),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .rx_par_err  (rx_par_err),
        .rx_frame_err(rx_frame_err),
        .rx_overrun  (rx_overrun)
    );

endmodule

// File: tb/sl_unit_bench.sv
module sl_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 307200;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop_one = 1'b1;
    logic [2:0] cfg_tx_rate = 3'd7;
    logic [2:0] cfg_rx_rate = 3'd7;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd, rxd;
    logic       rx_ack = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid, rx_par_err, rx_frame_err, rx_overrun;
    logic       loop_sel = 1'b1;
    logic       rx_man = 1'b1;
    logic       ovr_exp = 1'b0;

    int checks = 0;
    int fails = 0;
    int rx_seen = 0;
    bit run_done = 0;

    typedef struct {
        logic [7:0] d;
        bit pe;
        bit fe;
        bit ov;
    } rx_exp_t;

    rx_exp_t rxq[$];
    int seg_lvl[$];
    int seg_len[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    assign rxd = loop_sel ? txd : rx_man;

    sl_unit #(.CLK_HZ(CLK_HZ)) u_sl_unit (
        .clk(clk), .rst_n(rst_n),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop_one(cfg_stop_one), .cfg_tx_rate(cfg_tx_rate), .cfg_rx_rate(cfg_rx_rate),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_ack(rx_ack), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frame_err(rx_frame_err), .rx_overrun(rx_overrun)
    );

    function automatic int bdiv(input int code);
        int b;
        case (code)
            0: b = 110;   1: b = 150;   2: b = 300;   3: b = 600;
            4: b = 1200;  5: b = 2400;  6: b = 4800;  default: b = 9600;
        endcase
        return (CLK_HZ + 8 * b) / (16 * b);
    endfunction

    function automatic void chk(input bit ok, input string req, input string what,
                                input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endfunction

    function automatic void push_frame();
        int d;
        int n;
        int stop_ticks;
        logic [7:0] dm;
        rx_exp_t e;
        d  = bdiv(int'(cfg_tx_rate));
        n  = int'(cfg_len) + 5;
        dm = tx_data & (8'hFF >> (3 - int'(cfg_len)));
        seg_lvl.push_back(0); seg_len.push_back(16 * d);
        for (int i = 0; i < n; i++) begin
            seg_lvl.push_back(int'(dm[i])); seg_len.push_back(16 * d);
        end
        if (cfg_par_en) begin
            seg_lvl.push_back(int'((^dm) ^ cfg_par_odd)); seg_len.push_back(16 * d);
        end
        stop_ticks = cfg_stop_one ? 16 : ((cfg_len == 2'd0) ? 24 : 32);
        seg_lvl.push_back(1); seg_len.push_back(stop_ticks * d);
        if (loop_sel) begin
            e.d = dm; e.pe = 0; e.fe = 0; e.ov = ovr_exp;
            rxq.push_back(e);
        end
    endfunction

    // transmit reference model, compared on every clock
    always @(negedge clk) begin
        if (!rst_n) begin
            seg_lvl.delete();
            seg_len.delete();
        end else begin
            int exp_lvl;
            bit exp_rdy;
            exp_rdy = (seg_len.size() == 0);
            exp_lvl = exp_rdy ? 1 : seg_lvl[0];
            chk(int'(txd) == exp_lvl, "R1 R2 R3 R4 R5 R8", "txd", int'(txd), exp_lvl);
            chk(tx_ready == exp_rdy, "R7", "tx_ready", int'(tx_ready), int'(exp_rdy));
            if (!exp_rdy) begin
                seg_len[0] = seg_len[0] - 1;
                if (seg_len[0] == 0) begin
                    void'(seg_len.pop_front());
                    void'(seg_lvl.pop_front());
                end
            end else if (tx_valid) begin
                push_frame();
            end
        end
    end

    // receive checker
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_seen++;
            if (rxq.size() == 0) begin
                chk(0, "R9 R10", "unexpected rx_valid", 1, 0);
            end else begin
                rx_exp_t e;
                e = rxq.pop_front();
                chk(rx_data == e.d, "R1 R10", "rx_data", int'(rx_data), int'(e.d));
                chk(rx_par_err == e.pe, "R12", "rx_par_err", int'(rx_par_err), int'(e.pe));
                chk(rx_frame_err == e.fe, "R11", "rx_frame_err", int'(rx_frame_err), int'(e.fe));
                chk(rx_overrun == e.ov, "R13", "rx_overrun", int'(rx_overrun), int'(e.ov));
            end
        end
    end

    task automatic set_cfg(input logic [1:0] len, input logic pe, input logic odd,
                           input logic one, input logic [2:0] txr, input logic [2:0] rxr);
        @(posedge clk); #1;
        cfg_len = len; cfg_par_en = pe; cfg_par_odd = odd; cfg_stop_one = one;
        cfg_tx_rate = txr; cfg_rx_rate = rxr;
    endtask

    task automatic send(input logic [7:0] d);
        @(posedge clk); #1;
        tx_data = d;
        tx_valid = 1'b1;
        do @(negedge clk); while (!tx_ready);
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(tx_ready && seg_len.size() == 0 && rxq.size() == 0));
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic rx_bit(input logic v, input int cyc);
        rx_man = v;
        repeat (cyc) @(posedge clk);
        #1;
    endtask

    task automatic rx_frame(input int n, input logic [7:0] d, input bit pen,
                            input logic pval, input logic stopv, input int div);
        @(posedge clk); #1;
        rx_bit(1'b0, 16 * div);
        for (int i = 0; i < n; i++) rx_bit(d[i], 16 * div);
        if (pen) rx_bit(pval, 16 * div);
        rx_bit(stopv, 16 * div);
        rx_bit(1'b1, 16 * div);
    endtask

    task automatic expect_rx(input logic [7:0] d, input bit pe, input bit fe, input bit ov);
        rx_exp_t e;
        e.d = d; e.pe = pe; e.fe = fe; e.ov = ov;
        rxq.push_back(e);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!run_done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int seen_before;
        repeat (3) @(posedge clk);
        #1;
        // reset state
        chk(txd == 1'b1, "R7", "reset txd", int'(txd), 1);
        chk(tx_ready == 1'b1, "R7", "reset tx_ready", int'(tx_ready), 1);
        chk(rx_valid == 1'b0, "R10", "reset rx_valid", int'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R1 R5 R10: 8 data bits, no parity, one stop, 9600
        set_cfg(2'd3, 0, 0, 1, 3'd7, 3'd7);
        send(8'hA5);
        wait_idle();

        // R7: back-to-back bytes
        send(8'h3C);
        send(8'hC3);
        wait_idle();

        // R2 R3 R4: 7 bits, even parity, two stop bits
        set_cfg(2'd2, 1, 0, 0, 3'd7, 3'd7);
        send(8'hD6);
        wait_idle();

        // R3: 6 bits, odd parity, one stop
        set_cfg(2'd1, 1, 1, 1, 3'd7, 3'd7);
        send(8'h2B);
        wait_idle();

        // R4 R10: 5 bits, wide stop gives 1.5 bits, upper data bits dropped
        set_cfg(2'd0, 0, 0, 0, 3'd7, 3'd7);
        send(8'hFF);
        wait_idle();

        // R3: odd sense ignored with parity off
        set_cfg(2'd3, 0, 1, 0, 3'd7, 3'd7);
        send(8'h81);
        wait_idle();

        // R8: settings changed in mid-character
        set_cfg(2'd3, 1, 0, 0, 3'd7, 3'd7);
        send(8'h96);
        repeat (60) @(posedge clk);
        #1;
        cfg_len = 2'd0; cfg_par_en = 0; cfg_par_odd = 1; cfg_stop_one = 1;
        cfg_tx_rate = 3'd6; cfg_rx_rate = 3'd6;
        wait_idle();

        // R6: transmit at 4800 while receiving at 9600
        set_cfg(2'd3, 0, 0, 1, 3'd6, 3'd7);
        loop_sel = 1'b0;
        expect_rx(8'h5A, 0, 0, 0);
        fork
            send(8'h71);
            rx_frame(8, 8'h5A, 0, 1'b0, 1'b1, bdiv(7));
        join
        wait_idle();

        // R9: short low glitch produces nothing, then a good frame
        set_cfg(2'd3, 0, 0, 1, 3'd7, 3'd7);
        seen_before = rx_seen;
        rx_bit(1'b0, 6);
        rx_bit(1'b1, 200);
        chk(rx_seen == seen_before, "R9", "glitch produced characters", rx_seen - seen_before, 0);
        expect_rx(8'h44, 0, 0, 0);
        rx_frame(8, 8'h44, 0, 1'b0, 1'b1, bdiv(7));
        wait_idle();

        // R11: low stop bit
        expect_rx(8'h0F, 0, 1, 0);
        rx_frame(8, 8'h0F, 0, 1'b0, 1'b0, bdiv(7));
        wait_idle();

        // R12: wrong parity bit (even sense, data 0x07 has three ones, correct bit is 1)
        set_cfg(2'd3, 1, 0, 1, 3'd7, 3'd7);
        expect_rx(8'h07, 1, 0, 0);
        rx_frame(8, 8'h07, 1, 1'b0, 1'b1, bdiv(7));
        wait_idle();
        // correct parity, odd sense, 6 bits
        set_cfg(2'd1, 1, 1, 1, 3'd7, 3'd7);
        expect_rx(8'h15, 0, 0, 0);
        rx_frame(6, 8'h15, 1, 1'b0, 1'b1, bdiv(7));
        wait_idle();

        // R13: two characters without acknowledge
        loop_sel = 1'b1;
        set_cfg(2'd3, 0, 0, 1, 3'd7, 3'd7);
        rx_ack = 1'b0;
        ovr_exp = 1'b0;
        send(8'h11);
        ovr_exp = 1'b1;
        send(8'h22);
        wait_idle();
        rx_ack = 1'b1;
        ovr_exp = 1'b0;
        repeat (4) @(posedge clk);
        send(8'h33);
        wait_idle();

        // R5: slowest rate, 5 bits with 1.5 stop bits
        set_cfg(2'd0, 1, 1, 0, 3'd0, 3'd0);
        send(8'h0A);
        wait_idle();

        chk(rxq.size() == 0, "R10", "characters missing", rxq.size(), 0);
        run_done = 1;
        finish_run();
    end

endmodule